// File: doc/BRIEF.md
# Stereo Audio Frame FIFO Controller

This block sits between a processor register port and the serial shifter of a stereo audio link. Software queues outgoing 32-bit frames into a transmit queue by writing one register. It drains incoming frames from a receive queue by reading another. Each frame carries two 16-bit samples: the left sample in bits 31:16 and the right sample in bits 15:0. The nominal rate is 16 kHz per channel. On the line side, frames leave and arrive through plain valid/ready handshakes. The serial bit shifter and the clock divider logic live outside this block. The divider settings are only held here and read back.

Four interrupt lines report queue events: transmit below its mark, receive watermark reached, transmit empty, and receive overflow. A loopback mode moves frames straight from the transmit queue into the receive queue, one per cycle, without using the line. Either queue can be flushed by writing a 1 to a command bit. The receive watermark comes from a 3-bit code. Illegal code values fall back to the default code.

Top module: `audio_frame_ctrl`

## Requirements
- R1: After reset, control reads 0, status reads 0x0000000C, FIFO status reads 0, FIFO control reads 0x00000028, and `irq_tx_empty` and `irq_tx_wm` are high while the other two interrupts are low.
- R2: The word index is `reg_addr[5:2]`. Index 0 is control, 1 is status, 2 is read data, 3 is write data, 4 is FIFO control and 5 is FIFO status. Indices 6 to 15 read 0. In control, bit 0 enables transmit, bit 1 enables receive and bit 2 selects loopback. Bits 23:18 hold the receive divider and bits 30:25 hold the transmit divider. All other control bits read 0.
- R3: A write to index 3 appends the write data to the transmit queue, which is 32 frames deep. A write to a full queue is discarded and the level stays at 32.
- R4: A read of index 2 returns the oldest receive frame and removes it. When the receive queue is empty, the read returns 0 and the level does not change.
- R5: The status bits are live values: bit 0 is TX full, bit 1 is RX full, bit 2 is TX empty and bit 3 is RX empty.
- R6: FIFO status shows the transmit level in bits 5:0 and the receive level in bits 21:16.
- R7: FIFO control bits 4:2 store the receive code. Code 0 means 1 frame, 1 means 4, 2 means 8, 3 means 16 and 4 means 30. Codes 5 to 7 are stored as 2.
- R8: Writing 1 to FIFO control bit 0 empties the receive queue and forces the receive code to 2, even if the same write carries a different code. Writing 1 to bit 1 empties the transmit queue.
- R9: FIFO control bits 6:5 always read 01. `irq_tx_wm` is high while the transmit level is below 4.
- R10: `irq_tx_empty` is high exactly while the transmit queue holds no frame.
- R11: `irq_rx_wm` goes high for one cycle after a push that brings the receive level equal to the mark selected by the code.
- R12: A frame that arrives while the receive queue is full is discarded. `irq_rx_overflow` goes high for one cycle after it.
- R13: `tx_valid` is high when transmit is enabled, loopback is off and the transmit queue is not empty. `tx_data` shows the oldest frame, and that frame leaves on a cycle with `tx_valid` and `tx_ready` both high. `rx_ready` is high when receive is enabled and loopback is off.
- R14: With loopback, transmit and receive all enabled, one transmit frame per cycle moves into the receive queue in order, and nothing is offered on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on read data) |
| reg_addr | input | 6 | Byte address in the 64-byte window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| tx_valid | output | 1 | Outgoing frame available |
| tx_ready | input | 1 | Line side takes the outgoing frame |
| tx_data | output | 32 | Outgoing frame |
| rx_valid | input | 1 | Incoming frame present |
| rx_ready | output | 1 | Line input accepted |
| rx_data | input | 32 | Incoming frame |
| irq_tx_wm | output | 1 | Transmit level below its mark |
| irq_rx_wm | output | 1 | Receive watermark pulse |
| irq_tx_empty | output | 1 | Transmit queue empty |
| irq_rx_overflow | output | 1 | Receive overflow pulse |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never both high in the same cycle. They also assume that line inputs are held steady across a clock edge. The bench drives every strobe, address and line signal on the falling edge and issues one register access per task. It samples all results on a falling edge, after the rising edge that commits them. It never raises `rx_valid` while loopback is selected, so the two receive sources never compete.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic [3:0] {
      IDX_CTRL  = 4'd0,
      IDX_STAT  = 4'd1,
      IDX_RDAT  = 4'd2,
      IDX_WDAT  = 4'd3,
      IDX_FCTL  = 4'd4,
      IDX_FSTAT = 4'd5
   } reg_idx_e;

   typedef struct packed {
      logic [5:0] tx_div;
      logic [5:0] rx_div;
      logic       loop;
      logic       rx_en;
      logic       tx_en;
   } ctrl_t;

   localparam logic [2:0] RX_CODE_DEFAULT = 3'b010;
   localparam logic [1:0] TX_CODE_FIXED   = 2'b01;

   // code to frame count for the receive mark
   function automatic logic [5:0] rx_mark(input logic [2:0] code);
      case (code)
         3'd0:    rx_mark = 6'd1;
         3'd1:    rx_mark = 6'd4;
         3'd2:    rx_mark = 6'd8;
         3'd3:    rx_mark = 6'd16;
         3'd4:    rx_mark = 6'd30;
         default: rx_mark = 6'd8;
      endcase
   endfunction

   function automatic logic [2:0] rx_code_fix(input logic [2:0] code);
      rx_code_fix = (code <= 3'd4) ? code : RX_CODE_DEFAULT;
   endfunction

endpackage

// File: rtl/afc_fifo.sv
module afc_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 32,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = empty ? '0 : mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   // R3: level never exceeds the depth
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R3: a push into a full queue without a pop leaves the level alone
   a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

   // R8: flush empties the queue
   a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/afc_rx_event.sv
module afc_rx_event (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arrive,
   input  logic       full,
   input  logic       flush,
   input  logic       pop_ok,
   input  logic [5:0] level,
   input  logic [5:0] mark,
   output logic       wm_pulse,
   output logic       ovf_pulse
);

   logic       push_ok;
   logic [5:0] level_nxt;

   assign push_ok   = arrive && !full && !flush;
   assign level_nxt = level + 6'(push_ok) - 6'(pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wm_pulse  <= 1'b0;
         ovf_pulse <= 1'b0;
      end else begin
         wm_pulse  <= push_ok && (level_nxt == mark);
         ovf_pulse <= arrive && full && !flush;
      end
   end

   // R11: a watermark pulse always follows an accepted frame
   a_r11_wm_after_push: assert property (@(posedge clk) disable iff (!rst_n)
      wm_pulse |-> $past(arrive && !full));

   // R12: an overflow pulse always follows a full queue
   a_r12_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(full));

endmodule

// File: rtl/audio_frame_ctrl.sv
module audio_frame_ctrl
   import afc_pkg::*;
#(
   parameter int DW      = 32,
   parameter int DEPTH   = 32,
   parameter int TX_MARK = 4,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [5:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        tx_valid,
   input  logic        tx_ready,
   output logic [31:0] tx_data,
   input  logic        rx_valid,
   output logic        rx_ready,
   input  logic [31:0] rx_data,
   output logic        irq_tx_wm,
   output logic        irq_rx_wm,
   output logic        irq_tx_empty,
   output logic        irq_rx_overflow
);

   generate
      if (DEPTH < 30 || DEPTH > 63) begin : g_bad_depth
         $error("DEPTH must reach the top receive mark and fit a 6-bit level");
      end
      if (DW != 32) begin : g_bad_width
         $error("frames are 32 bits wide");
      end
      if (TX_MARK < 1 || TX_MARK > DEPTH) begin : g_bad_mark
         $error("TX_MARK out of range");
      end
   endgenerate

   ctrl_t       ctrl_q;
   logic [2:0]  rx_code_q;
   logic [3:0]  idx;
   logic        wr_ctrl, wr_data, wr_fctl, rd_data;
   logic        tx_flush, rx_flush;
   logic        tx_full, tx_empty, rx_full, rx_empty;
   logic [CW-1:0] tx_count, rx_count;
   logic [5:0]  tx_lvl, rx_lvl;
   logic [31:0] tx_head, rx_head, rx_in;
   logic        tx_take, lb_move, tx_pop, rx_arrive;
   logic        unused_bits;

   assign idx     = reg_addr[5:2];
   assign wr_ctrl = reg_wr && (idx == IDX_CTRL);
   assign wr_data = reg_wr && (idx == IDX_WDAT);
   assign wr_fctl = reg_wr && (idx == IDX_FCTL);
   assign rd_data = reg_rd && (idx == IDX_RDAT);
   assign rx_flush = wr_fctl && reg_wdata[0];
   assign tx_flush = wr_fctl && reg_wdata[1];
   assign unused_bits = ^reg_addr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         rx_code_q <= RX_CODE_DEFAULT;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.tx_en  <= reg_wdata[0];
            ctrl_q.rx_en  <= reg_wdata[1];
            ctrl_q.loop   <= reg_wdata[2];
            ctrl_q.rx_div <= reg_wdata[23:18];
            ctrl_q.tx_div <= reg_wdata[30:25];
         end
         if (rx_flush)     rx_code_q <= RX_CODE_DEFAULT;
         else if (wr_fctl) rx_code_q <= rx_code_fix(reg_wdata[4:2]);
      end
   end

   // line side and loopback steering
   assign tx_valid  = ctrl_q.tx_en && !ctrl_q.loop && !tx_empty;
   assign tx_data   = tx_head;
   assign tx_take   = tx_valid && tx_ready;
   assign lb_move   = ctrl_q.loop && ctrl_q.tx_en && ctrl_q.rx_en && !tx_empty && !tx_flush;
   assign tx_pop    = tx_take || lb_move;
   assign rx_ready  = ctrl_q.rx_en && !ctrl_q.loop;
   assign rx_arrive = lb_move || (rx_valid && rx_ready);
   assign rx_in     = ctrl_q.loop ? tx_head : rx_data;

   afc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(wr_data), .wdata(reg_wdata),
      .pop(tx_pop), .rdata(tx_head),
      .count(tx_count), .full(tx_full), .empty(tx_empty)
   );

   afc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_arrive), .wdata(rx_in),
      .pop(rd_data), .rdata(rx_head),
      .count(rx_count), .full(rx_full), .empty(rx_empty)
   );

   assign tx_lvl = 6'(tx_count);
   assign rx_lvl = 6'(rx_count);

   afc_rx_event u_rx_evt (
      .clk(clk), .rst_n(rst_n),
      .arrive(rx_arrive), .full(rx_full), .flush(rx_flush),
      .pop_ok(rd_data && !rx_empty),
      .level(rx_lvl), .mark(rx_mark(rx_code_q)),
      .wm_pulse(irq_rx_wm), .ovf_pulse(irq_rx_overflow)
   );

   assign irq_tx_wm    = (tx_lvl < 6'(TX_MARK));
   assign irq_tx_empty = tx_empty;

   always_comb begin
      case (idx)
         IDX_CTRL:  reg_rdata = {1'b0, ctrl_q.tx_div, 1'b0, ctrl_q.rx_div, 15'd0,
                                 ctrl_q.loop, ctrl_q.rx_en, ctrl_q.tx_en};
         IDX_STAT:  reg_rdata = {28'd0, rx_empty, tx_empty, rx_full, tx_full};
         IDX_RDAT:  reg_rdata = rx_head;
         IDX_FCTL:  reg_rdata = {25'd0, TX_CODE_FIXED, rx_code_q, 2'b00};
         IDX_FSTAT: reg_rdata = {10'd0, rx_lvl, 10'd0, tx_lvl};
         default:   reg_rdata = 32'd0;
      endcase
   end

   // R13: nothing is offered on the line while loopback is selected
   a_r13_no_line_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.loop |-> (!tx_valid && !rx_ready));

   // R10: an empty transmit queue offers nothing
   a_r10_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx_empty |-> !tx_valid);

   // R14: a loopback move shifts one frame between the queues
   a_r14_loop_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_move && !rx_full && !rd_data && !rx_flush && !wr_data) |=>
         (tx_count == $past(tx_count) - 1'b1) && (rx_count == $past(rx_count) + 1'b1));

endmodule

// File: tb/audio_frame_ctrl_test.sv
module audio_frame_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_valid, tx_ready = 1'b0;
   logic [31:0] tx_data;
   logic        rx_valid = 1'b0, rx_ready;
   logic [31:0] rx_data = '0;
   logic        irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_overflow;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   audio_frame_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .irq_tx_wm(irq_tx_wm), .irq_rx_wm(irq_rx_wm),
      .irq_tx_empty(irq_tx_empty), .irq_rx_overflow(irq_rx_overflow)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = {i, 2'b00}; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] i, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = {i, 2'b00};
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rx_push(input logic [31:0] d, output logic wm, output logic ovf);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0;
      wm = irq_rx_wm; ovf = irq_rx_overflow;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(4'd0, d); chk("R1 ctrl", d, 32'h0);
      rd(4'd1, d); chk("R1 status", d, 32'hC);
      rd(4'd5, d); chk("R1 fstat", d, 32'h0);
      rd(4'd4, d); chk("R1 fctl", d, 32'h28);
      chk("R1 irqs", {irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_overflow}, 32'b1010);
      chk("R13 idle line", {tx_valid, rx_ready}, 32'b00);
   endtask

   task automatic t_ctrl();
      logic [31:0] d;
      wr(4'd0, 32'hFFFF_FFF8);
      rd(4'd0, d); chk("R2 ctrl fields", d, 32'h7EFC_0000);
      wr(4'd0, 32'h0);
      rd(4'd9, d); chk("R2 unmapped", d, 32'h0);
   endtask

   task automatic t_tx_fill();
      logic [31:0] d;
      for (int i = 0; i < 33; i++) begin
         wr(4'd3, 32'h100 + i);
         if (i == 2) chk("R9 wm below mark", {31'd0, irq_tx_wm}, 32'd1);
         if (i == 3) chk("R9 wm at mark", {31'd0, irq_tx_wm}, 32'd0);
         if (i == 0) chk("R10 not empty", {31'd0, irq_tx_empty}, 32'd0);
      end
      rd(4'd5, d); chk("R3 full drop level", d, 32'h20);
      rd(4'd1, d); chk("R5 tx full", d, 32'h9);
      wr(4'd4, 32'h0A);
      rd(4'd5, d); chk("R8 tx flush", d, 32'h0);
      chk("R10 empty after flush", {31'd0, irq_tx_empty}, 32'd1);
   endtask

   task automatic t_line_tx();
      logic [31:0] d;
      wr(4'd0, 32'h1);
      wr(4'd3, 32'hAAAA_0001);
      wr(4'd3, 32'hBBBB_0002);
      chk("R13 valid", {31'd0, tx_valid}, 32'd1);
      chk("R13 head", tx_data, 32'hAAAA_0001);
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
      chk("R13 next head", tx_data, 32'hBBBB_0002);
      rd(4'd5, d); chk("R6 tx level", d, 32'h1);
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
      chk("R13 drained", {31'd0, tx_valid}, 32'd0);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_codes();
      logic [31:0] d;
      for (int c = 0; c < 8; c++) begin
         wr(4'd4, 32'(c) << 2);
         rd(4'd4, d);
         chk("R7 code", d, (c <= 4) ? (32'h20 | (32'(c) << 2)) : 32'h28);
         chk("R9 tx code", {30'd0, d[6:5]}, 32'd1);
      end
   endtask

   task automatic t_rx_wm();
      logic [31:0] d;
      logic wm, ovf;
      wr(4'd4, 32'h04);
      wr(4'd0, 32'h2);
      chk("R13 rx ready", {31'd0, rx_ready}, 32'd1);
      for (int i = 0; i < 4; i++) begin
         rx_push(32'h1234_0000 + i, wm, ovf);
         chk("R11 wm pulse", {31'd0, wm}, (i == 3) ? 32'd1 : 32'd0);
      end
      @(negedge clk);
      chk("R11 one cycle", {31'd0, irq_rx_wm}, 32'd0);
      rd(4'd5, d); chk("R6 rx level", d, 32'h0004_0000);
      rd(4'd2, d); chk("R4 oldest", d, 32'h1234_0000);
      rd(4'd2, d); chk("R4 second", d, 32'h1234_0001);
      wr(4'd4, 32'h0D);
      rd(4'd4, d); chk("R8 rx flush code", d, 32'h28);
      rd(4'd2, d); chk("R4 empty read", d, 32'h0);
      rd(4'd5, d); chk("R4 empty level", d, 32'h0);
      rd(4'd1, d); chk("R5 both empty", d, 32'hC);
   endtask

   task automatic t_overflow();
      logic [31:0] d;
      logic wm, ovf;
      int wm_hits = 0;
      int wm_at = -1;
      wr(4'd4, 32'h10);
      for (int i = 0; i < 32; i++) begin
         rx_push(32'h5000 + i, wm, ovf);
         if (wm) begin wm_hits++; wm_at = i; end
      end
      chk("R11 mark 30 hits", 32'(wm_hits), 32'd1);
      chk("R11 mark 30 index", 32'(wm_at), 32'd29);
      rx_push(32'hDEAD, wm, ovf);
      chk("R12 overflow pulse", {31'd0, ovf}, 32'd1);
      @(negedge clk);
      chk("R12 pulse ends", {31'd0, irq_rx_overflow}, 32'd0);
      rd(4'd5, d); chk("R12 level held", d, 32'h0020_0000);
      rd(4'd1, d); chk("R5 rx full", d, 32'h6);
      rd(4'd2, d); chk("R12 oldest kept", d, 32'h5000);
      wr(4'd4, 32'h01);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_loop();
      logic [31:0] d;
      for (int i = 0; i < 3; i++) wr(4'd3, 32'hC0DE_0000 + i);
      wr(4'd0, 32'h7);
      chk("R14 no rx line", {31'd0, rx_ready}, 32'd0);
      repeat (5) @(negedge clk);
      chk("R14 no tx line", {31'd0, tx_valid}, 32'd0);
      rd(4'd5, d); chk("R14 moved", d, 32'h0003_0000);
      for (int i = 0; i < 3; i++) begin
         rd(4'd2, d); chk("R14 order", d, 32'hC0DE_0000 + i);
      end
      wr(4'd0, 32'h0);
   endtask

   initial begin
      #(4 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_tx_fill();
      t_line_tx();
      t_codes();
      t_rx_wm();
      t_overflow();
      t_loop();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule